// File: doc/BRIEF.md
# Priority Bus Arbiter with Grant Chain

This block decides which master may own a shared parallel bus next. Masters sit in numbered slots along a chain. Each slot may ask for the bus at one of four interrupt priority levels or on a separate request path for direct-memory-access masters. A central arbiter merges all requests as a logical OR, picks one winning line and raises the grant for that line only.

The grant enters the chain at slot 0 and ripples slot by slot. A slot that is waiting on the granted line keeps the grant: it raises its acknowledge and stops the grant from going further. Any other slot passes the grant on unchanged. A slot that is configured as unpopulated is a plain pass-through. After the acknowledge, the chosen slot waits until bus-busy is low, then takes the bus, drives bus-busy and drops the acknowledge. Because selection does not depend on bus-busy, the next master can be picked and acknowledged while the current one is still moving data. If a grant goes unclaimed for too long, the arbiter withdraws it and picks again.

Top module: `bus_arb_chain`

## Requirements
- R1: During and just after reset, no grant line, acknowledge, bus-busy, slot acknowledge or slot ownership is asserted.
- R2: A slot's level code 0 to 3 selects priority levels 4 to 7 on grant bits 0 to 3. A code of NUM_LEVELS (4) or above selects the direct-memory-access path on grant bit NUM_LEVELS. A pending direct-memory-access request wins over every level, and a higher level wins over a lower one.
- R3: At most one grant line is asserted in any cycle.
- R4: The arbiter drops the grant in the cycle after it sees acknowledge, and it raises no new grant while acknowledge is asserted.
- R5: A slot waiting on the granted line raises its own acknowledge and holds that grant back from all slots further down. When two slots request on the same line, the slot with the lower index wins.
- R6: An unpopulated slot forwards every grant line unchanged, and its request, level and done inputs have no effect.
- R7: An acknowledged slot takes ownership only while bus-busy is low. It then drives bus-busy, releases acknowledge and keeps the bus until its done input is seen. At most one slot owns the bus.
- R8: While one slot owns the bus, the arbiter still grants and another slot still acknowledges. That slot takes over only after the owner releases bus-busy.
- R9: A grant that no slot acknowledges stays up for exactly TIMEOUT cycles. The arbiter then withdraws it and arbitrates again among the requests still pending.
- R10: On an idle bus, a request presented before rising edge E0 shows as a grant after edge E1, as an acknowledge after E2, and as ownership (with the grant low) after E3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req_i | input | NUM_SLOTS | Per-slot bus request from the attached master |
| dev_lvl_i | input | NUM_SLOTS*LVL_W | Per-slot level code, LVL_W bits per slot, slot 0 in the low bits |
| dev_done_i | input | NUM_SLOTS | Per-slot pulse ending the slot's bus ownership |
| bus_grant_o | output | NUM_LEVELS+1 | Grant lines leaving the arbiter; top bit is the direct-memory-access grant |
| bus_req_o | output | NUM_LEVELS+1 | OR of all slot requests per line |
| sack_o | output | 1 | OR of slot acknowledges |
| bbsy_o | output | 1 | OR of slot bus-busy drives |
| slot_ack_o | output | NUM_SLOTS | Per-slot acknowledge |
| slot_own_o | output | NUM_SLOTS | Per-slot bus ownership |

## Verification
The assertions assume that a slot's master holds its level code steady while it requests and raises done only while it owns the bus. The bench changes level codes only when both slots are idle and pulses done only after ownership has been seen. The timeout property assumes that a requester which drops its request before the grant arrives leaves that grant unclaimed. The bench creates this case on purpose, by withdrawing a direct-memory-access request one cycle after raising it.

// File: rtl/arb_pkg.sv
package arb_pkg;

   typedef enum logic [1:0] {
      ARB_IDLE  = 2'd0,
      ARB_OFFER = 2'd1,
      ARB_DRAIN = 2'd2
   } arb_state_t;

   typedef enum logic [1:0] {
      ND_IDLE = 2'd0,
      ND_WANT = 2'd1,
      ND_HELD = 2'd2,
      ND_OWN  = 2'd3
   } node_state_t;

endpackage

// File: rtl/arb_wired_or.sv
module arb_wired_or #(
   parameter int SOURCES = 4,
   parameter int WIDTH   = 1
) (
   input  logic [SOURCES*WIDTH-1:0] drive_i,
   output logic [WIDTH-1:0]         line_o
);

   if (SOURCES < 1) begin : g_bad_src
      $error("arb_wired_or: SOURCES must be at least 1");
   end
   if (WIDTH < 1) begin : g_bad_w
      $error("arb_wired_or: WIDTH must be at least 1");
   end

   always_comb begin
      line_o = '0;
      for (int s = 0; s < SOURCES; s++) begin
         line_o = line_o | drive_i[s*WIDTH +: WIDTH];
      end
   end

endmodule

// File: rtl/arb_slot_node.sv
module arb_slot_node
   import arb_pkg::*;
#(
   parameter int NUM_LEVELS = 4,
   parameter bit PRESENT    = 1'b1,
   localparam int GRANTS    = NUM_LEVELS + 1,
   localparam int LVL_W     = $clog2(GRANTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dev_req_i,
   input  logic [LVL_W-1:0]  dev_lvl_i,
   input  logic              dev_done_i,
   input  logic              bbsy_i,
   input  logic [GRANTS-1:0] grant_in_i,
   output logic [GRANTS-1:0] grant_out_o,
   output logic [GRANTS-1:0] req_o,
   output logic              ack_o,
   output logic              own_o
);

   if (NUM_LEVELS < 1) begin : g_bad_lvl
      $error("arb_slot_node: NUM_LEVELS must be at least 1");
   end

   if (PRESENT) begin : g_live
      node_state_t      st_q;
      logic [LVL_W-1:0] lvl_q;
      logic [LVL_W-1:0] lvl_pick;
      logic [GRANTS-1:0] lvl_oh;
      logic             offered;

      // codes at or above NUM_LEVELS all select the DMA line
      always_comb begin
         if (32'(dev_lvl_i) >= NUM_LEVELS) lvl_pick = LVL_W'(NUM_LEVELS);
         else                              lvl_pick = dev_lvl_i;
      end

      assign lvl_oh  = {{(GRANTS-1){1'b0}}, 1'b1} << lvl_q;
      assign offered = |(grant_in_i & lvl_oh);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q  <= ND_IDLE;
            lvl_q <= '0;
         end else begin
            unique case (st_q)
               ND_IDLE: begin
                  if (dev_req_i) begin
                     st_q  <= ND_WANT;
                     lvl_q <= lvl_pick;
                  end
               end
               ND_WANT: begin
                  if (offered)         st_q <= ND_HELD;
                  else if (!dev_req_i) st_q <= ND_IDLE;
               end
               ND_HELD: begin
                  if (!bbsy_i) st_q <= ND_OWN;
               end
               ND_OWN: begin
                  if (dev_done_i) st_q <= ND_IDLE;
               end
               default: st_q <= ND_IDLE;
            endcase
         end
      end

      // a waiting or acknowledging slot keeps its own line from downstream
      assign grant_out_o = ((st_q == ND_WANT) || (st_q == ND_HELD)) ?
                           (grant_in_i & ~lvl_oh) : grant_in_i;
      assign req_o = (st_q == ND_WANT) ? lvl_oh : '0;
      assign ack_o = (st_q == ND_HELD);
      assign own_o = (st_q == ND_OWN);

      AST_TAKE_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
         (st_q == ND_HELD && bbsy_i) |=> (st_q == ND_HELD)) // R7
         else $error("slot took bus while busy");
      AST_TAKE_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
         (st_q == ND_HELD && !bbsy_i) |=> (own_o && !ack_o)) // R7
         else $error("slot failed to take free bus");
      AST_ACK_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ack_o) |-> $past(offered)) // R5
         else $error("acknowledge without grant");
   end else begin : g_empty
      logic unused_inputs;
      assign unused_inputs = ^{dev_req_i, dev_lvl_i, dev_done_i, bbsy_i, clk, rst_n};
      assign grant_out_o = grant_in_i;
      assign req_o       = '0;
      assign ack_o       = 1'b0;
      assign own_o       = 1'b0;
   end

endmodule

// File: rtl/arb_central.sv
module arb_central
   import arb_pkg::*;
#(
   parameter int NUM_LEVELS = 4,
   parameter int TIMEOUT    = 16,
   localparam int GRANTS    = NUM_LEVELS + 1,
   localparam int DMA_BIT   = NUM_LEVELS,
   localparam int TMR_W     = $clog2(TIMEOUT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [GRANTS-1:0] req_i,
   input  logic              sack_i,
   output logic [GRANTS-1:0] grant_o
);

   if (TIMEOUT < 2) begin : g_bad_to
      $error("arb_central: TIMEOUT must be at least 2");
   end

   arb_state_t        st_q;
   logic [TMR_W-1:0]  tmr_q;
   logic [GRANTS-1:0] pick;

   // highest bit wins: DMA on top, then level 7 down to level 4
   always_comb begin
      pick = '0;
      for (int b = 0; b < GRANTS; b++) begin
         if (req_i[b]) pick = {{(GRANTS-1){1'b0}}, 1'b1} << b;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ARB_IDLE;
         tmr_q   <= '0;
         grant_o <= '0;
      end else begin
         unique case (st_q)
            ARB_IDLE: begin
               tmr_q <= '0;
               if (!sack_i && (|req_i)) begin
                  grant_o <= pick;
                  st_q    <= ARB_OFFER;
               end
            end
            ARB_OFFER: begin
               if (sack_i) begin
                  grant_o <= '0;
                  st_q    <= ARB_DRAIN;
               end else if (tmr_q == TMR_W'(TIMEOUT - 1)) begin
                  grant_o <= '0;
                  st_q    <= ARB_IDLE;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            ARB_DRAIN: begin
               if (!sack_i) st_q <= ARB_IDLE;
            end
            default: begin
               st_q    <= ARB_IDLE;
               grant_o <= '0;
            end
         endcase
      end
   end

   // independent count of how long the current grant has stood
   logic [TMR_W:0] held_q;
   always_ff @(posedge clk) begin
      if (!rst_n)          held_q <= '0;
      else if (|grant_o)   held_q <= held_q + 1'b1;
      else                 held_q <= '0;
   end

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o)) // R3
      else $error("more than one grant");
   AST_ACK_DROPS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (sack_i && (|grant_o)) |=> (grant_o == '0)) // R4
      else $error("grant held past acknowledge");
   AST_NO_GRANT_UNDER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (sack_i && (grant_o == '0)) |=> (grant_o == '0)) // R4
      else $error("grant raised during acknowledge");
   AST_DMA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ARB_IDLE && !sack_i && req_i[DMA_BIT]) |=> grant_o[DMA_BIT]) // R2
      else $error("DMA request not served first");
   AST_GRANT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant_o) |-> (held_q < (TMR_W+1)'(TIMEOUT))) // R9
      else $error("grant outlived timeout");

endmodule

// File: rtl/bus_arb_chain.sv
module bus_arb_chain
   import arb_pkg::*;
#(
   parameter int                 NUM_SLOTS    = 4,
   parameter int                 NUM_LEVELS   = 4,
   parameter int                 TIMEOUT      = 16,
   parameter logic [NUM_SLOTS-1:0] SLOT_PRESENT = '1,
   localparam int                GRANTS       = NUM_LEVELS + 1,
   localparam int                LVL_W        = $clog2(GRANTS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_SLOTS-1:0]       dev_req_i,
   input  logic [NUM_SLOTS*LVL_W-1:0] dev_lvl_i,
   input  logic [NUM_SLOTS-1:0]       dev_done_i,
   output logic [GRANTS-1:0]          bus_grant_o,
   output logic [GRANTS-1:0]          bus_req_o,
   output logic                       sack_o,
   output logic                       bbsy_o,
   output logic [NUM_SLOTS-1:0]       slot_ack_o,
   output logic [NUM_SLOTS-1:0]       slot_own_o
);

   if (NUM_SLOTS < 1) begin : g_bad_slots
      $error("bus_arb_chain: NUM_SLOTS must be at least 1");
   end

   logic [GRANTS-1:0]           chain [0:NUM_SLOTS];
   logic [NUM_SLOTS*GRANTS-1:0] req_flat;
   logic                        unused_chain_end;

   assign chain[0]         = bus_grant_o;
   assign unused_chain_end = ^chain[NUM_SLOTS];

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      arb_slot_node #(
         .NUM_LEVELS (NUM_LEVELS),
         .PRESENT    (SLOT_PRESENT[s])
      ) u_node (
         .clk         (clk),
         .rst_n       (rst_n),
         .dev_req_i   (dev_req_i[s]),
         .dev_lvl_i   (dev_lvl_i[s*LVL_W +: LVL_W]),
         .dev_done_i  (dev_done_i[s]),
         .bbsy_i      (bbsy_o),
         .grant_in_i  (chain[s]),
         .grant_out_o (chain[s+1]),
         .req_o       (req_flat[s*GRANTS +: GRANTS]),
         .ack_o       (slot_ack_o[s]),
         .own_o       (slot_own_o[s])
      );
   end

   arb_wired_or #(.SOURCES(NUM_SLOTS), .WIDTH(GRANTS)) u_req_or (
      .drive_i (req_flat),
      .line_o  (bus_req_o)
   );
   arb_wired_or #(.SOURCES(NUM_SLOTS), .WIDTH(1)) u_ack_or (
      .drive_i (slot_ack_o),
      .line_o  (sack_o)
   );
   arb_wired_or #(.SOURCES(NUM_SLOTS), .WIDTH(1)) u_busy_or (
      .drive_i (slot_own_o),
      .line_o  (bbsy_o)
   );

   arb_central #(
      .NUM_LEVELS (NUM_LEVELS),
      .TIMEOUT    (TIMEOUT)
   ) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (bus_req_o),
      .sack_i  (sack_o),
      .grant_o (bus_grant_o)
   );

   AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_own_o)) // R7
      else $error("two bus owners");
   AST_ONE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_ack_o)) // R5
      else $error("two acknowledges");
   AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      ((slot_ack_o | slot_own_o) & ~SLOT_PRESENT) == '0) // R6
      else $error("empty slot became active");

endmodule

// File: tb/bus_arb_chain_test.sv
module bus_arb_chain_test;

   localparam int N   = 4;
   localparam int L   = 4;
   localparam int G   = L + 1;
   localparam int LW  = $clog2(G);
   localparam int TO  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  dev_req = '0;
   logic [N*LW-1:0] dev_lvl = '0;
   logic [N-1:0]  dev_done = '0;
   logic [G-1:0]  bus_grant, bus_req;
   logic          sack, bbsy;
   logic [N-1:0]  slot_ack, slot_own;

   int total = 0;
   int bad   = 0;
   int mon_bad = 0;
   int cycles = 0;
   logic prev_sack = 1'b0;
   logic [G-1:0] prev_grant = '0;

   always #2 clk = ~clk;

   bus_arb_chain #(
      .NUM_SLOTS(N), .NUM_LEVELS(L), .TIMEOUT(TO), .SLOT_PRESENT(4'b1011)
   ) uut (
      .clk(clk), .rst_n(rst_n), .dev_req_i(dev_req), .dev_lvl_i(dev_lvl),
      .dev_done_i(dev_done), .bus_grant_o(bus_grant), .bus_req_o(bus_req),
      .sack_o(sack), .bbsy_o(bbsy), .slot_ack_o(slot_ack), .slot_own_o(slot_own)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic set_lvl(input int s, input int v);
      dev_lvl[s*LW +: LW] = LW'(v);
   endtask

   task automatic wait_own(input logic [N-1:0] target);
      for (int i = 0; i < 60 && slot_own !== target; i++) step();
   endtask

   task automatic pulse_done(input int s);
      dev_done[s] = 1'b1;
      step();
      dev_done[s] = 1'b0;
   endtask

   // monitor: one grant at most (R3), grant gone after acknowledge (R4)
   always @(negedge clk) begin
      if (rst_n) begin
         if (!$onehot0(bus_grant)) mon_bad++;
         if (prev_sack && bus_grant != '0) mon_bad++;
         prev_sack  <= sack;
         prev_grant <= bus_grant;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic run_pair(input int a, input int b);
      int win, lose;
      string tg;
      win  = (b > a) ? 1 : 0;
      lose = 1 - win;
      tg   = (a == b) ? "R5 same-line upstream wins" : "R2 priority order";
      step();
      set_lvl(0, a);
      set_lvl(1, b);
      dev_req[0] = 1'b1;
      dev_req[1] = 1'b1;
      wait_own(N'(1) << win);
      check(slot_own == (N'(1) << win), tg, int'(slot_own), 1 << win);
      dev_req[win] = 1'b0;
      for (int i = 0; i < 5; i++) step();
      check(slot_ack[lose] && slot_own == (N'(1) << win),
            "R8 next master acknowledged under busy",
            int'({slot_ack, slot_own}), (1 << (lose + 4)) | (1 << win));
      pulse_done(win);
      wait_own(N'(1) << lose);
      check(slot_own == (N'(1) << lose), "R7 takeover after release",
            int'(slot_own), 1 << lose);
      dev_req[lose] = 1'b0;
      pulse_done(lose);
      wait_own('0);
      step();
   endtask

   initial begin
      int gcount;
      bit claimed;
      repeat (3) step();
      check(bus_grant == '0 && sack == 1'b0, "R1 reset grant/ack",
            int'({bus_grant, sack}), 0);
      check(bbsy == 1'b0 && slot_own == '0 && slot_ack == '0, "R1 reset busy/own",
            int'({bbsy, slot_own, slot_ack}), 0);
      rst_n = 1'b1;
      step();
      check(bus_grant == '0, "R1 after reset grant", int'(bus_grant), 0);
      check(slot_own == '0 && bbsy == 1'b0, "R1 after reset owner", int'(slot_own), 0);

      // exhaustive pair sweep over all level codes, slots 0 and 1
      for (int a = 0; a < G; a++)
         for (int b = 0; b < G; b++)
            run_pair(a, b);

      // R6: requests on the empty slot do nothing
      step();
      set_lvl(2, 4);
      dev_req[2] = 1'b1;
      dev_done[2] = 1'b1;
      for (int i = 0; i < 12; i++) step();
      check(bus_grant == '0 && slot_own == '0 && bus_req == '0,
            "R6 empty slot inputs ignored", int'({bus_grant, slot_own}), 0);
      dev_req[2] = 1'b0;
      dev_done[2] = 1'b0;

      // R10 latency, through the empty slot to slot 3 (R6 pass-through)
      step();
      set_lvl(3, 2);
      dev_req[3] = 1'b1;
      step();
      check(bus_grant == '0, "R10 no grant after E0", int'(bus_grant), 0);
      step();
      check(bus_grant == G'(4), "R10 grant after E1", int'(bus_grant), 4);
      step();
      check(slot_ack == 4'b1000 && sack, "R10 ack after E2 via empty slot R6",
            int'(slot_ack), 8);
      step();
      check(slot_own == 4'b1000 && bus_grant == '0 && !sack && bbsy,
            "R10 own after E3", int'({slot_own, bus_grant}), 8 << G);
      dev_req[3] = 1'b0;
      pulse_done(3);
      wait_own('0);
      step();

      // R9: DMA request withdrawn before its grant arrives
      set_lvl(0, 4);
      set_lvl(1, 1);
      dev_req[0] = 1'b1;
      dev_req[1] = 1'b1;
      step();
      dev_req[0] = 1'b0;
      gcount  = 0;
      claimed = 1'b0;
      for (int i = 0; i < 40; i++) begin
         step();
         if (bus_grant[L]) gcount++;
         if (slot_own[0] || slot_ack[0]) claimed = 1'b1;
      end
      check(gcount == TO && !claimed, "R9 unclaimed grant lasts TIMEOUT",
            gcount, TO);
      check(slot_own == 4'b0010, "R9 rearbitration serves level 5",
            int'(slot_own), 2);
      dev_req[1] = 1'b0;
      pulse_done(1);
      wait_own('0);
      step();

      check(mon_bad == 0, "R3 R4 grant monitor", mon_bad, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule